// File: doc/BRIEF.md
# Receive Completion Ring Threshold Controller

This block looks after one receive completion ring that lives in host memory, seen from the network controller side. Hardware posts completion entries at the producer index, and the host driver reports how far it has consumed by writing the consumer index. From one 32-bit control word and two runtime inputs, the block works out how many entries the ring holds. It also computes the host address where the next entry goes, keeps the valid and empty counts, and raises a sticky interrupt status bit when the occupancy crosses a programmable threshold.

The entry format (one, two or four 32-bit words) and the ring size (4 KB or 8 KB) are chosen at runtime, so the entry count ranges from 256 to 2048. Both indices wrap at that count. One slot is always kept unused, so a full ring and an empty ring can be told apart. The host may be allowed to overwrite the producer index. A flag tells the bus master to use 64-bit addressing for the ring.

Top module: `cq_thresh_ctrl`

## Requirements
- R1: After reset the control word is zero and the block has producer 0, consumer 0, valid count 0, interrupt status 0, next address 0 and the 64-bit flag at 0. Control word layout: bits 31:8 base address bits 31:8 (base bits 7:0 are always 0), bits 7:4 threshold field, bits 3:2 entry format, bit 1 producer host-write enable, bit 0 64-bit-address flag.
- R2: The entry format code selects the bytes per entry: 00 gives 4 bytes, 01 and 10 give 8 bytes, 11 gives 16 bytes. `ring_8k`=1 selects 8192 ring bytes and 0 selects 4096. The entry count is ring bytes divided by entry bytes. The reported indices are the stored values modulo the entry count.
- R3: `post_ack` is high when `post_req` is high, the ring is not full and no effective host producer write happens in that cycle. Each acknowledged post advances the producer index by one, wrapping from count−1 to 0.
- R4: `next_addr` equals the base plus the producer index times the entry bytes.
- R5: `valid_cnt` = (producer − consumer) mod count and `empty_cnt` = count − 1 − `valid_cnt`. `ring_full` is high when `empty_cnt` is 0, and no post is accepted while it is high.
- R6: A consumer write loads its data modulo the entry count in the next cycle.
- R7: A producer write loads its data modulo the entry count only when control bit 1 is set; otherwise it has no effect. An effective producer write takes precedence over a post in the same cycle.
- R8: With `thr_mode_valid`=0, the interrupt status becomes 1 at the clock edge after `empty_cnt` ≤ 4 × threshold field holds.
- R9: With `thr_mode_valid`=1, the interrupt status becomes 1 at the clock edge after `valid_cnt` ≥ 4 × threshold field holds.
- R10: The interrupt status stays 1 until `irq_clr` is pulsed. The edge that samples `irq_clr` clears it, and it is set again one edge later if the condition still holds.
- R11: `addr64` follows control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word data |
| ring_8k | input | 1 | Ring size select: 1 = 8 KB, 0 = 4 KB |
| thr_mode_valid | input | 1 | Threshold mode: 1 = compare valid count, 0 = compare empty count |
| post_req | input | 1 | Hardware request to post one entry |
| post_ack | output | 1 | Post accepted this cycle |
| prod_we | input | 1 | Host write of the producer index |
| prod_wdata | input | 11 | Producer index write data |
| cons_we | input | 1 | Host write of the consumer index |
| cons_wdata | input | 11 | Consumer index write data |
| irq_clr | input | 1 | Write-1-to-clear pulse for the interrupt status |
| prod_idx | output | 11 | Producer index |
| cons_idx | output | 11 | Consumer index |
| valid_cnt | output | 11 | Entries posted and not yet consumed |
| empty_cnt | output | 11 | Free entries |
| ring_full | output | 1 | No free entry |
| next_addr | output | 32 | Host address of the next entry |
| addr64 | output | 1 | 64-bit addressing required for the ring |
| irq_stat | output | 1 | Sticky threshold interrupt status |

## Verification
The bench targets the points where the index arithmetic is most likely to break. It covers a producer that sits below the consumer and must wrap, which a design without the modulo mask would show as a huge valid count. It covers a full ring that must refuse a post, which a design that forgets the spare slot would accept and then report as empty. It also covers a geometry change that shrinks the entry count under stored indices. On the interrupt side, it probes the zero threshold in both modes, where a strict comparison in place of an inclusive one would miss the edge. It also checks the single clear cycle before the status is set again, which a design that let the condition win over the clear would never show. Finally, it checks that a producer write is dropped when the enable bit is clear and that an enabled producer write beats a simultaneous post.

// File: rtl/cq_pkg.sv
package cq_pkg;

    // Entry format codes held in the control word
    typedef enum logic [1:0] {
        FMT_ONE_WORD  = 2'b00,
        FMT_TWO_EXT   = 2'b01,
        FMT_TWO_CSUM  = 2'b10,
        FMT_FOUR_WORD = 2'b11
    } ent_fmt_e;

    // Control word, most significant field first
    typedef struct packed {
        logic [23:0] base_hi;      // base address bits 31:8
        logic [3:0]  thr_field;    // threshold, scaled by 4
        ent_fmt_e    fmt;          // entry format
        logic        prod_host_en; // host may write producer index
        logic        addr64;       // ring in 64-bit space
    } ctl_word_t;

    localparam int BASE_ALIGN_BITS = 8;

    function automatic logic [2:0] entry_shift(input ent_fmt_e f);
        case (f)
            FMT_ONE_WORD:  entry_shift = 3'd2;
            FMT_FOUR_WORD: entry_shift = 3'd4;
            default:       entry_shift = 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/cq_geometry.sv
module cq_geometry
    import cq_pkg::*;
#(
    parameter int RING_LOG2 = 12,
    parameter int IDX_W     = RING_LOG2 - 1
) (
    input  ent_fmt_e         fmt,
    input  logic             ring_large,
    output logic [2:0]       ent_shift,
    output logic [IDX_W-1:0] idx_mask
);

    logic [IDX_W:0] count;

    always_comb begin
        ent_shift = entry_shift(fmt);
        count     = (IDX_W+1)'(1) << (RING_LOG2 + int'(ring_large) - int'(ent_shift));
        idx_mask  = IDX_W'(count - (IDX_W+1)'(1));
    end

endmodule

// File: rtl/cq_ring_index.sv
module cq_ring_index #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_mask,
    input  logic             post_req,
    input  logic             prod_host_wr,
    input  logic [IDX_W-1:0] prod_wdata,
    input  logic             cons_we,
    input  logic [IDX_W-1:0] cons_wdata,
    output logic             post_ack,
    output logic [IDX_W-1:0] prod_m,
    output logic [IDX_W-1:0] cons_m,
    output logic [IDX_W-1:0] valid_cnt,
    output logic [IDX_W-1:0] empty_cnt,
    output logic             full
);

    typedef struct packed {
        logic [IDX_W-1:0] prod;
        logic [IDX_W-1:0] cons;
    } idx_state_t;

    idx_state_t st_d, st_q;

    always_comb begin
        prod_m    = st_q.prod & idx_mask;
        cons_m    = st_q.cons & idx_mask;
        valid_cnt = (prod_m - cons_m) & idx_mask;
        empty_cnt = idx_mask - valid_cnt;
        full      = (empty_cnt == '0);
        post_ack  = post_req && !full && !prod_host_wr;

        st_d = st_q;
        if (prod_host_wr)
            st_d.prod = prod_wdata & idx_mask;
        else if (post_ack)
            st_d.prod = (prod_m + IDX_W'(1)) & idx_mask;
        if (cons_we)
            st_d.cons = cons_wdata & idx_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_POST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        post_ack |=> st_q.prod == (($past(prod_m) + IDX_W'(1)) & $past(idx_mask))); // R3

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !prod_host_wr) |=> st_q.prod == $past(st_q.prod)); // R5

    AST_CONS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cons_we |=> st_q.cons == ($past(cons_wdata) & $past(idx_mask))); // R6

endmodule

// File: rtl/cq_thresh_irq.sv
module cq_thresh_irq #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       thr_field,
    input  logic             mode_valid,
    input  logic [IDX_W-1:0] valid_cnt,
    input  logic [IDX_W-1:0] empty_cnt,
    input  logic             irq_clr,
    output logic             irq
);

    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t       st_d, st_q;
    logic [IDX_W-1:0] thr_eff;
    logic             hit;

    always_comb begin
        thr_eff = IDX_W'({thr_field, 2'b00});
        hit     = mode_valid ? (valid_cnt >= thr_eff) : (empty_cnt <= thr_eff);
        st_d    = st_q;
        if (irq_clr)  st_d.irq = 1'b0;
        else if (hit) st_d.irq = 1'b1;
        irq = st_q.irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_EMPTY_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_valid && empty_cnt <= IDX_W'({thr_field, 2'b00}) && !irq_clr) |=> irq); // R8

    AST_VALID_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && valid_cnt >= IDX_W'({thr_field, 2'b00}) && !irq_clr) |=> irq); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R10

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !irq); // R10

endmodule

// File: rtl/cq_thresh_ctrl.sv
module cq_thresh_ctrl
    import cq_pkg::*;
#(
    parameter int RING_LOG2 = 12,
    localparam int IDX_W    = RING_LOG2 - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [31:0]      ctl_wdata,
    input  logic             ring_8k,
    input  logic             thr_mode_valid,
    input  logic             post_req,
    output logic             post_ack,
    input  logic             prod_we,
    input  logic [IDX_W-1:0] prod_wdata,
    input  logic             cons_we,
    input  logic [IDX_W-1:0] cons_wdata,
    input  logic             irq_clr,
    output logic [IDX_W-1:0] prod_idx,
    output logic [IDX_W-1:0] cons_idx,
    output logic [IDX_W-1:0] valid_cnt,
    output logic [IDX_W-1:0] empty_cnt,
    output logic             ring_full,
    output logic [31:0]      next_addr,
    output logic             addr64,
    output logic             irq_stat
);

    typedef struct packed {
        ctl_word_t ctl;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic [2:0]       ent_shift;
    logic [IDX_W-1:0] idx_mask;
    logic             prod_host_wr;
    logic [31:0]      base_addr;

    always_comb begin
        st_d = st_q;
        if (ctl_we) st_d.ctl = ctl_word_t'(ctl_wdata);
        prod_host_wr = prod_we && st_q.ctl.prod_host_en;
        base_addr    = {st_q.ctl.base_hi, {BASE_ALIGN_BITS{1'b0}}};
        next_addr    = base_addr + (32'(prod_idx) << ent_shift);
        addr64       = st_q.ctl.addr64;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cq_geometry #(.RING_LOG2(RING_LOG2), .IDX_W(IDX_W)) u_geom (
        .fmt        (st_q.ctl.fmt),
        .ring_large (ring_8k),
        .ent_shift  (ent_shift),
        .idx_mask   (idx_mask)
    );

    cq_ring_index #(.IDX_W(IDX_W)) u_idx (
        .clk          (clk),
        .rst_n        (rst_n),
        .idx_mask     (idx_mask),
        .post_req     (post_req),
        .prod_host_wr (prod_host_wr),
        .prod_wdata   (prod_wdata),
        .cons_we      (cons_we),
        .cons_wdata   (cons_wdata),
        .post_ack     (post_ack),
        .prod_m       (prod_idx),
        .cons_m       (cons_idx),
        .valid_cnt    (valid_cnt),
        .empty_cnt    (empty_cnt),
        .full         (ring_full)
    );

    cq_thresh_irq #(.IDX_W(IDX_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .thr_field  (st_q.ctl.thr_field),
        .mode_valid (thr_mode_valid),
        .valid_cnt  (valid_cnt),
        .empty_cnt  (empty_cnt),
        .irq_clr    (irq_clr),
        .irq        (irq_stat)
    );

    AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        next_addr[1:0] == 2'b00); // R4

    AST_PROD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_we && !st_q.ctl.prod_host_en && !post_req && !ctl_we) |=> prod_idx == $past(prod_idx)); // R7

    AST_FULL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full |-> !post_ack); // R5

endmodule

// File: tb/tb_cq_thresh_ctrl.sv
module tb_cq_thresh_ctrl;

    localparam int IDX_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_we = 1'b0;
    logic [31:0]      ctl_wdata = '0;
    logic             ring_8k = 1'b0;
    logic             thr_mode_valid = 1'b0;
    logic             post_req = 1'b0;
    logic             post_ack;
    logic             prod_we = 1'b0;
    logic [IDX_W-1:0] prod_wdata = '0;
    logic             cons_we = 1'b0;
    logic [IDX_W-1:0] cons_wdata = '0;
    logic             irq_clr = 1'b0;
    logic [IDX_W-1:0] prod_idx, cons_idx, valid_cnt, empty_cnt;
    logic             ring_full, addr64, irq_stat;
    logic [31:0]      next_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    cq_thresh_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ring_8k(ring_8k), .thr_mode_valid(thr_mode_valid),
        .post_req(post_req), .post_ack(post_ack),
        .prod_we(prod_we), .prod_wdata(prod_wdata),
        .cons_we(cons_we), .cons_wdata(cons_wdata), .irq_clr(irq_clr),
        .prod_idx(prod_idx), .cons_idx(cons_idx), .valid_cnt(valid_cnt),
        .empty_cnt(empty_cnt), .ring_full(ring_full), .next_addr(next_addr),
        .addr64(addr64), .irq_stat(irq_stat)
    );

    typedef struct packed {
        logic [31:0]      ctl;
        logic             big;
        logic             mode;
        logic [IDX_W-1:0] prod;
        logic [IDX_W-1:0] cons;
        logic [IDX_W-1:0] exp_valid;
        logic [IDX_W-1:0] exp_empty;
        logic [31:0]      exp_addr;
        logic             exp_irq;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0001_0002, 1'b0, 1'b0, 11'd5,    11'd2,    11'd3,    11'd1020, 32'h0001_0014, 1'b0},
        '{32'h2000_0126, 1'b0, 1'b0, 11'd3,    11'd10,   11'd505,  11'd6,    32'h2000_0118, 1'b1},
        '{32'hABCD_EFFE, 1'b1, 1'b1, 11'd511,  11'd0,    11'd511,  11'd0,    32'hABCE_0EF0, 1'b1},
        '{32'h0000_401A, 1'b1, 1'b1, 11'd1000, 11'd1000, 11'd0,    11'd1023, 32'h0000_5F40, 1'b0},
        '{32'h0000_0002, 1'b1, 1'b1, 11'd2,    11'd2047, 11'd3,    11'd2044, 32'h0000_0008, 1'b1},
        '{32'h00FF_FF06, 1'b0, 1'b0, 11'd100,  11'd101,  11'd511,  11'd0,    32'h0100_0220, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [31:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_idx(input logic [IDX_W-1:0] p, input logic [IDX_W-1:0] c);
        prod_we = 1'b1; prod_wdata = p; cons_we = 1'b1; cons_wdata = c;
        @(negedge clk);
        prod_we = 1'b0; cons_we = 1'b0;
    endtask

    task automatic wr_cons(input logic [IDX_W-1:0] c);
        cons_we = 1'b1; cons_wdata = c;
        @(negedge clk);
        cons_we = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 prod", 32'(prod_idx), 0);
        check("R1 valid", 32'(valid_cnt), 0);
        check("R1 empty", 32'(empty_cnt), 1023);
        check("R1 addr", next_addr, 0);
        check("R1 irq", 32'(irq_stat), 0);
        check("R11 addr64 reset", 32'(addr64), 0);

        // Table walk: R2 R4 R5 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            ring_8k = VECS[i].big;
            thr_mode_valid = VECS[i].mode;
            wr_ctl(VECS[i].ctl);
            wr_idx(VECS[i].prod, VECS[i].cons);
            pulse_clr();
            @(negedge clk);
            check($sformatf("R5 valid vec%0d", i), 32'(valid_cnt), 32'(VECS[i].exp_valid));
            check($sformatf("R5 empty vec%0d", i), 32'(empty_cnt), 32'(VECS[i].exp_empty));
            check($sformatf("R4 addr vec%0d", i), next_addr, VECS[i].exp_addr);
            check($sformatf("R2 full vec%0d", i), 32'(ring_full), 32'(VECS[i].exp_empty == 0));
            check($sformatf("R8/R9 irq vec%0d", i), 32'(irq_stat), 32'(VECS[i].exp_irq));
        end

        // R11 flag
        wr_ctl(32'h0000_0003);
        check("R11 addr64 set", 32'(addr64), 1);

        // R2 geometry shrink: 8KB one-word (2048) then 4KB four-word (256)
        ring_8k = 1'b1; thr_mode_valid = 1'b0;
        wr_ctl(32'h0000_0002);
        wr_idx(11'd1500, 11'd0);
        check("R2 prod large", 32'(prod_idx), 1500);
        ring_8k = 1'b0;
        wr_ctl(32'h0000_000E);
        check("R2 prod wrapped", 32'(prod_idx), 220);
        check("R2 empty 256 ring", 32'(empty_cnt), 35);

        // R3/R5 posting: 4KB one-word ring, base 0x8000
        wr_ctl(32'h0000_8002);
        wr_idx(11'd1022, 11'd0);
        post_req = 1'b1;
        #1;
        check("R3 ack", 32'(post_ack), 1);
        @(negedge clk);
        check("R3 advance", 32'(prod_idx), 1023);
        check("R4 addr last slot", next_addr, 32'h0000_8FFC);
        check("R5 full", 32'(ring_full), 1);
        check("R5 ack blocked", 32'(post_ack), 0);
        @(negedge clk);
        check("R5 no advance when full", 32'(prod_idx), 1023);
        post_req = 1'b0;
        wr_cons(11'd1);
        post_req = 1'b1;
        @(negedge clk);
        post_req = 1'b0;
        check("R3 wrap to zero", 32'(prod_idx), 0);
        check("R4 addr wrap", next_addr, 32'h0000_8000);

        // R6 consumer write masked by 256-entry ring
        wr_ctl(32'h0000_800E);
        wr_cons(11'd300);
        check("R6 cons masked", 32'(cons_idx), 44);

        // R7 host write wins over post; disabled write ignored
        wr_ctl(32'h0000_8002);
        wr_idx(11'd3, 11'd0);
        post_req = 1'b1; prod_we = 1'b1; prod_wdata = 11'd7;
        #1;
        check("R7 post refused during host write", 32'(post_ack), 0);
        @(negedge clk);
        post_req = 1'b0; prod_we = 1'b0;
        check("R7 host write wins", 32'(prod_idx), 7);
        wr_ctl(32'h0000_8000);
        prod_we = 1'b1; prod_wdata = 11'd9;
        @(negedge clk);
        prod_we = 1'b0;
        check("R7 locked write ignored", 32'(prod_idx), 7);

        // R10 sticky and clear: thr field 1 (4), empty-count mode
        thr_mode_valid = 1'b0;
        wr_ctl(32'h0000_8012);
        wr_idx(11'd0, 11'd5);
        pulse_clr();
        @(negedge clk);
        check("R8 empty at threshold", 32'(irq_stat), 1);
        wr_cons(11'd0);
        @(negedge clk);
        check("R10 sticky", 32'(irq_stat), 1);
        pulse_clr();
        @(negedge clk);
        check("R10 cleared", 32'(irq_stat), 0);
        wr_cons(11'd5);
        @(negedge clk);
        pulse_clr();
        check("R10 clear cycle", 32'(irq_stat), 0);
        @(negedge clk);
        check("R10 set again", 32'(irq_stat), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule